// File: doc/BRIEF.md
# Packet DRAM Bus Turnaround Tracker

This block keeps the earliest-free times of three shared resources of a packet-based DRAM device: the row command bus, the column command bus and the data bus. A scheduler presents one access per cycle with a bank, a row, a direction flag and the current time. The block applies the row-command spacing rule for that access and any precharge floor. It then adds a direction-change bubble to the column and data buses and returns the three updated free times one cycle later.

For every bank the block keeps the row most recently opened, the time until which that row stays open, and a short history of row matches. It also keeps the bank and direction of the previous access. That state decides the spacing of the next access. Data movement is not part of this block.

Top module: `turn_bubble_tracker`

## Requirements
- R1: After reset all three free times are zero, every bank has row 0 with an open-until time of 0 and an empty history, the previous bank is 0 and the previous direction is read.
- R2: When the access goes to the same bank as the previous access, the row-bus free time advances by `T_CYC - T_PKT` (6 by default). For a different bank it advances by `T_R2R` (8 by default).
- R3: An access is a hit (`rsp_hit_o` = 1) only when its row equals the bank's stored row and the bank's open-until time is strictly greater than the request time. Each access stores its row in its bank and sets the open-until time to request time + `ROW_HOLD` (20 by default).
- R4: A miss while the bank's open-until time is still later than the request time needs precharge (`rsp_pre_o` = 1). The row-bus free time is then raised to at least request time + `T_PRE` (10 by default). In every other case `rsp_pre_o` is 0.
- R5: A write that follows a read adds `BUB_RW` (3 by default) to both the column-bus and the data-bus free times.
- R6: A read that follows a write to the same bank adds `BUB_WR` (5 by default) to both the column-bus and the data-bus free times.
- R7: A read that follows a write to a different bank, and two accesses in the same direction, add no bubble.
- R8: Every access shifts one bit into its bank's history at bit 0: 1 if the row equals the stored row, whatever the open-until time. `rsp_hist_o` shows the updated history of the bank accessed.
- R9: `rsp_valid_o` is high exactly one cycle after `req_valid_i`. Without a request, all outputs keep their values.
- R10: Each access becomes the previous access (bank and direction) for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Access present this cycle |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_now_i | input | TIME_W | Current time of the request |
| rsp_valid_o | output | 1 | Updated results present |
| row_free_o | output | TIME_W | Row command bus free time |
| col_free_o | output | TIME_W | Column command bus free time |
| dat_free_o | output | TIME_W | Data bus free time |
| rsp_hit_o | output | 1 | The access hit the open row |
| rsp_pre_o | output | 1 | The access needed precharge |
| rsp_hist_o | output | HIST_W | Updated row-match history of the accessed bank |

## Verification
The hardest case to reach is a row that matches the stored row after the open-until time has passed. It must count as a miss without precharge, yet still shift a 1 into the history. The bench reaches it by opening a row, then returning to the same bank and row with a request time past the hold window. It also touches a bank never opened since reset with row 0. A second delicate case is the precharge floor: a miss on an open row must come soon after that row opened, with the row bus free time still below request time + `T_PRE`, so that the floor takes effect. Directed accesses build both cases, and a pseudo-random mix of banks, rows and directions follows them.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    typedef enum logic {
        ACC_RD = 1'b0,
        ACC_WR = 1'b1
    } acc_dir_e;

    // Turnaround bubble for a direction change
    function automatic int unsigned pick_bubble(
        input acc_dir_e    prev_dir,
        input acc_dir_e    cur_dir,
        input logic        same_bank,
        input int unsigned bub_rw,
        input int unsigned bub_wr
    );
        if (prev_dir == ACC_RD && cur_dir == ACC_WR)
            return bub_rw;
        else if (prev_dir == ACC_WR && cur_dir == ACC_RD && same_bank)
            return bub_wr;
        else
            return 0;
    endfunction

endpackage

// File: rtl/tbt_bank_table.sv
module tbt_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 8,
    parameter int TIME_W    = 32,
    parameter int HIST_W    = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] rd_bank_i,
    output logic [ROW_W-1:0]  rd_row_o,
    output logic [TIME_W-1:0] rd_until_o,
    output logic [HIST_W-1:0] rd_hist_o,
    input  logic              wr_en_i,
    input  logic [ROW_W-1:0]  wr_row_i,
    input  logic [TIME_W-1:0] wr_until_i,
    input  logic [HIST_W-1:0] wr_hist_i
);

    logic [ROW_W-1:0]  row_q   [NUM_BANKS];
    logic [TIME_W-1:0] until_q [NUM_BANKS];
    logic [HIST_W-1:0] hist_q  [NUM_BANKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                row_q[b]   <= '0;
                until_q[b] <= '0;
                hist_q[b]  <= '0;
            end
        end else if (wr_en_i) begin
            row_q[rd_bank_i]   <= wr_row_i;
            until_q[rd_bank_i] <= wr_until_i;
            hist_q[rd_bank_i]  <= wr_hist_i;
        end
    end

    assign rd_row_o   = row_q[rd_bank_i];
    assign rd_until_o = until_q[rd_bank_i];
    assign rd_hist_o  = hist_q[rd_bank_i];

endmodule

// File: rtl/tbt_spacing.sv
module tbt_spacing
    import tbt_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int T_CYC  = 10,
    parameter int T_PKT  = 4,
    parameter int T_R2R  = 8,
    parameter int T_PRE  = 10,
    parameter int BUB_RW = 3,
    parameter int BUB_WR = 5
) (
    input  logic              same_bank_i,
    input  logic              need_pre_i,
    input  acc_dir_e          prev_dir_i,
    input  acc_dir_e          cur_dir_i,
    input  logic [TIME_W-1:0] now_i,
    input  logic [TIME_W-1:0] row_free_i,
    input  logic [TIME_W-1:0] col_free_i,
    input  logic [TIME_W-1:0] dat_free_i,
    output logic [TIME_W-1:0] row_free_o,
    output logic [TIME_W-1:0] col_free_o,
    output logic [TIME_W-1:0] dat_free_o
);

    localparam logic [TIME_W-1:0] SAME_STEP = TIME_W'(T_CYC - T_PKT);
    localparam logic [TIME_W-1:0] DIFF_STEP = TIME_W'(T_R2R);
    localparam logic [TIME_W-1:0] PRE_GAP   = TIME_W'(T_PRE);

    logic [TIME_W-1:0] row_adv;
    logic [TIME_W-1:0] row_floor;
    logic [TIME_W-1:0] bubble;

    always_comb begin
        row_adv   = row_free_i + (same_bank_i ? SAME_STEP : DIFF_STEP);
        row_floor = now_i + PRE_GAP;
        if (need_pre_i && row_adv < row_floor)
            row_free_o = row_floor;
        else
            row_free_o = row_adv;
        bubble = TIME_W'(pick_bubble(prev_dir_i, cur_dir_i, same_bank_i,
                                     BUB_RW, BUB_WR));
        col_free_o = col_free_i + bubble;
        dat_free_o = dat_free_i + bubble;
    end

endmodule

// File: rtl/turn_bubble_tracker.sv
module turn_bubble_tracker
    import tbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 8,
    parameter int TIME_W    = 32,
    parameter int HIST_W    = 8,
    parameter int T_CYC     = 10,
    parameter int T_PKT     = 4,
    parameter int T_R2R     = 8,
    parameter int T_PRE     = 10,
    parameter int BUB_RW    = 3,
    parameter int BUB_WR    = 5,
    parameter int ROW_HOLD  = 20,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic              req_wr_i,
    input  logic [TIME_W-1:0] req_now_i,
    output logic              rsp_valid_o,
    output logic [TIME_W-1:0] row_free_o,
    output logic [TIME_W-1:0] col_free_o,
    output logic [TIME_W-1:0] dat_free_o,
    output logic              rsp_hit_o,
    output logic              rsp_pre_o,
    output logic [HIST_W-1:0] rsp_hist_o
);

    localparam logic [TIME_W-1:0] HOLD_T = TIME_W'(ROW_HOLD);

    logic [BANK_W-1:0] prev_bank_q;
    acc_dir_e          prev_dir_q;
    acc_dir_e          cur_dir;

    logic [ROW_W-1:0]  tab_row;
    logic [TIME_W-1:0] tab_until;
    logic [HIST_W-1:0] tab_hist;
    logic [HIST_W-1:0] hist_nx;

    logic same_bank, row_match, row_open, is_hit, need_pre;
    logic [TIME_W-1:0] row_nx, col_nx, dat_nx;

    assign cur_dir   = req_wr_i ? ACC_WR : ACC_RD;
    assign same_bank = (req_bank_i == prev_bank_q);
    assign row_match = (req_row_i == tab_row);
    assign row_open  = (tab_until > req_now_i);
    assign is_hit    = row_match && row_open;
    assign need_pre  = !row_match && row_open;
    assign hist_nx   = {tab_hist[HIST_W-2:0], row_match};

    tbt_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .TIME_W    (TIME_W),
        .HIST_W    (HIST_W)
    ) table_i (
        .clk        (clk),
        .rst        (rst),
        .rd_bank_i  (req_bank_i),
        .rd_row_o   (tab_row),
        .rd_until_o (tab_until),
        .rd_hist_o  (tab_hist),
        .wr_en_i    (req_valid_i),
        .wr_row_i   (req_row_i),
        .wr_until_i (req_now_i + HOLD_T),
        .wr_hist_i  (hist_nx)
    );

    tbt_spacing #(
        .TIME_W (TIME_W),
        .T_CYC  (T_CYC),
        .T_PKT  (T_PKT),
        .T_R2R  (T_R2R),
        .T_PRE  (T_PRE),
        .BUB_RW (BUB_RW),
        .BUB_WR (BUB_WR)
    ) spacing_i (
        .same_bank_i (same_bank),
        .need_pre_i  (need_pre),
        .prev_dir_i  (prev_dir_q),
        .cur_dir_i   (cur_dir),
        .now_i       (req_now_i),
        .row_free_i  (row_free_o),
        .col_free_i  (col_free_o),
        .dat_free_i  (dat_free_o),
        .row_free_o  (row_nx),
        .col_free_o  (col_nx),
        .dat_free_o  (dat_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_bank_q <= '0;
            prev_dir_q  <= ACC_RD;
            rsp_valid_o <= 1'b0;
            row_free_o  <= '0;
            col_free_o  <= '0;
            dat_free_o  <= '0;
            rsp_hit_o   <= 1'b0;
            rsp_pre_o   <= 1'b0;
            rsp_hist_o  <= '0;
        end else begin
            rsp_valid_o <= req_valid_i;
            if (req_valid_i) begin
                prev_bank_q <= req_bank_i;
                prev_dir_q  <= cur_dir;
                row_free_o  <= row_nx;
                col_free_o  <= col_nx;
                dat_free_o  <= dat_nx;
                rsp_hit_o   <= is_hit;
                rsp_pre_o   <= need_pre;
                rsp_hist_o  <= hist_nx;
            end
        end
    end

    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid_o |-> ($stable(row_free_o) && $stable(col_free_o) && $stable(dat_free_o)));

    // R5
    col_dat_lockstep_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> ((col_free_o - $past(col_free_o)) == (dat_free_o - $past(dat_free_o))));

    // R4
    pre_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_pre_o) |-> (row_free_o >= $past(req_now_i) + TIME_W'(T_PRE)));

    // R8
    hit_sets_hist_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_hit_o) |-> rsp_hist_o[0]);

    // R3
    hit_not_pre_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> !(rsp_hit_o && rsp_pre_o));

endmodule

// File: tb/turn_bubble_tracker_tb_top.sv
`timescale 1ns/1ps
module turn_bubble_tracker_tb_top;

    localparam int NB = 4, BW = 2, RW = 8, TW = 32, HW = 8;
    localparam int SAME_STEP = 6, DIFF_STEP = 8, PRE = 10;
    localparam int BRW = 3, BWR = 5, HOLD = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic          req_wr = 1'b0;
    logic [TW-1:0] req_now = '0;
    logic          rsp_valid, rsp_hit, rsp_pre;
    logic [TW-1:0] row_free, col_free, dat_free;
    logic [HW-1:0] rsp_hist;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    turn_bubble_tracker dut_i (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_bank_i(req_bank),
        .req_row_i(req_row), .req_wr_i(req_wr), .req_now_i(req_now),
        .rsp_valid_o(rsp_valid), .row_free_o(row_free), .col_free_o(col_free),
        .dat_free_o(dat_free), .rsp_hit_o(rsp_hit), .rsp_pre_o(rsp_pre),
        .rsp_hist_o(rsp_hist)
    );

    typedef struct {
        logic [TW-1:0] row, col, dat;
        logic          hit, pre;
        logic [HW-1:0] hist;
    } exp_t;

    exp_t exp_q[$];

    // reference state
    logic [RW-1:0] m_hot   [NB];
    logic [TW-1:0] m_until [NB];
    logic [HW-1:0] m_hist  [NB];
    logic [TW-1:0] m_row = 0, m_col = 0, m_dat = 0;
    logic [BW-1:0] m_lb = 0;
    logic          m_lw = 0;

    task automatic check(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic access(input int b, input int r, input bit wr, input int now);
        exp_t e;
        bit same, match, open;
        logic [TW-1:0] adv, flo;
        int bub;
        same  = (b == m_lb);
        match = (r == m_hot[b]);
        open  = (m_until[b] > now);
        adv   = m_row + (same ? SAME_STEP : DIFF_STEP);       // R2
        flo   = now + PRE;
        e.hit = match && open;                                // R3
        e.pre = !match && open;                               // R4
        e.row = (e.pre && adv < flo) ? flo : adv;
        bub   = (!m_lw && wr) ? BRW : ((m_lw && !wr && same) ? BWR : 0); // R5 R6 R7
        e.col = m_col + bub;
        e.dat = m_dat + bub;
        e.hist = {m_hist[b][HW-2:0], match};                  // R8
        m_hist[b] = e.hist;
        m_hot[b] = r;
        m_until[b] = now + HOLD;
        m_row = e.row; m_col = e.col; m_dat = e.dat;
        m_lb = b; m_lw = wr;                                  // R10
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_bank = b; req_row = r; req_wr = wr; req_now = now;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check("R9 unexpected response", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check("R2/R4 row free", row_free, e.row);
                    check("R5/R6/R7 col free", col_free, e.col);
                    check("R5/R6/R7 dat free", dat_free, e.dat);
                    check("R3 hit", rsp_hit, e.hit);
                    check("R4 precharge", rsp_pre, e.pre);
                    check("R8 history", rsp_hist, e.hist);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        int now;
        logic [TW-1:0] h_row;
        for (int i = 0; i < NB; i++) begin
            m_hot[i] = 0; m_until[i] = 0; m_hist[i] = 0;
        end
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 row free", row_free, 0);
        check("R1 col free", col_free, 0);
        check("R1 dat free", dat_free, 0);
        check("R1 valid", rsp_valid, 0);
        rst = 1'b0;
        @(negedge clk);

        access(0, 5, 0, 100);  // R2 same bank after reset, miss
        access(0, 5, 1, 105);  // R3 hit, R5 read->write
        access(0, 5, 0, 110);  // R6 write->read same bank
        access(1, 0, 1, 111);  // R8 match on unopened bank, no hit
        access(1, 3, 0, 112);  // R4 precharge floor, R6
        access(2, 0, 1, 113);
        access(3, 9, 0, 114);  // R7 write->read different bank
        access(3, 9, 0, 200);  // R3/R8 expired match: no hit, no pre
        access(3, 9, 0, 201);  // R7 same direction
        @(negedge clk); req_valid = 1'b0;
        repeat (3) @(negedge clk);
        h_row = row_free;
        // R9 idle: outputs hold
        repeat (4) @(negedge clk);
        check("R9 idle row hold", row_free, h_row);
        check("R9 idle valid low", rsp_valid, 0);

        lfsr = 32'hACE1_2345;
        now = 300;
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            now += 1 + int'(lfsr[10:8]);
            access(int'(lfsr[1:0]), int'(lfsr[4:3]), lfsr[6], now);
        end
        @(negedge clk); req_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 all responses seen", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule